// File: doc/BRIEF.md
# Nonvolatile Memory Access Qualifier

This block sits in front of a RAM-plus-nonvolatile-shadow memory controller. It decides whether the two active-low array transfer pins and the host access strobes may reach that controller. The transfer pins are a save pin (RAM to nonvolatile array) and a restore pin (nonvolatile array to RAM). Its inputs are a digital supply-good flag, a power-on event, the raw save and restore pins, and the host read and write strobes.

While the supply is good, two hold-off timers count clock cycles. The read path opens after a short interval. The write path, which also carries save requests, opens after a much longer one. Either timer restarts when the supply drops or a power-on event is seen.

A low on the save pin becomes a request only in these conditions:
- The pin was seen high while the write path was already open, so a pin held low through a power ramp is ignored.
- The pin then stays low for a minimum number of consecutive cycles, which rejects glitches.
- The restore pin is not low at any point in that low run.

Each qualifying pulse gives exactly one single-cycle request. The restore pin gives a single-cycle request on its first low sample, once it has been seen high with the read path open.

Top module: `nvram_guard`

## Requirements
- R1: While supply_ok_i is low, rd_en_o and wr_en_o are 0 in the same cycle, store_req_o and recall_req_o are 0 from the next cycle, and both hold-off timers restart from zero.
- R2: The read path opens only after RD_HOLD_CYC consecutive clock edges at which supply_ok_i is 1 and por_i is 0. A por_i high, sampled at any edge, restarts the count, and the read path is closed while por_i is high.
- R3: The write path opens only after WR_HOLD_CYC such consecutive edges. Both wr_en_o and store_req_o require the write path to be open.
- R4: rd_en_o is rd_req_i AND read path open AND store_ni==1 AND recall_ni==1. wr_en_o is the same expression with wr_req_i and the write path. A low level on either transfer pin blocks host access.
- R5: store_req_o goes high for one cycle after STORE_MIN_LOW_CYC consecutive edges with store_ni==0. Before that run, store_ni must have been sampled 1 with the write path open. A shorter low run gives no request.
- R6: One low run on store_ni gives at most one store_req_o pulse, however long the pin stays low.
- R7: A low run on store_ni that began before the write path opened, or that is still in progress when the write path closes, gives no request until store_ni has been seen 1 again with the write path open.
- R8: recall_ni==0, sampled at any edge of a store_ni low run, cancels that run. No store_req_o results from it.
- R9: recall_req_o goes high for one cycle on the first edge at which recall_ni==0, after recall_ni was sampled 1 with the read path open. It is not re-issued while the pin stays low.
- R10: While rst_ni is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above the lockout threshold |
| por_i | input | 1 | Power-on event, restarts the hold-off timers |
| store_ni | input | 1 | Raw save pin, active low |
| recall_ni | input | 1 | Raw restore pin, active low |
| rd_req_i | input | 1 | Host read strobe |
| wr_req_i | input | 1 | Host write strobe |
| store_req_o | output | 1 | Qualified single-cycle save request |
| recall_req_o | output | 1 | Qualified single-cycle restore request |
| rd_en_o | output | 1 | Host read enable |
| wr_en_o | output | 1 | Host write enable |

## Verification
The hardest situation to reach is a save pin that is already low when the write path opens. It is easy to misread as a fresh request. The stimulus reaches it by dropping the supply, raising it again with store_ni held low, and keeping the pin low well past the write hold-off. Only then does it release the pin and pulse it again. The same method drops the supply in the middle of a low run that is counting, and asserts the restore pin partway through a low run that would otherwise qualify.

// File: rtl/nvram_guard_pkg.sv
package nvram_guard_pkg;

  typedef enum logic [1:0] {
    PWR_DOWN = 2'd0,
    PWR_READ = 2'd1,
    PWR_FULL = 2'd2
  } pwr_state_e;

  function automatic pwr_state_e pwr_state(input logic up, input logic rd_done, input logic wr_done);
    if (!up)                return PWR_DOWN;
    else if (rd_done && wr_done) return PWR_FULL;
    else if (rd_done)       return PWR_READ;
    else                    return PWR_DOWN;
  endfunction

endpackage

// File: rtl/nvg_holdoff_timer.sv
module nvg_holdoff_timer #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic done_o
);
  localparam int unsigned CW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/nvg_pulse_qual.sv
// Arms on a high pin while enabled, fires once after MIN_LOW_CYC low samples.
module nvg_pulse_qual #(
  parameter int unsigned MIN_LOW_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic pin_ni,
  input  logic block_i,
  output logic fire_o
);
  localparam int unsigned CW = (MIN_LOW_CYC < 2) ? 1 : $clog2(MIN_LOW_CYC);
  localparam logic [CW-1:0] LAST = CW'((MIN_LOW_CYC < 1) ? 0 : MIN_LOW_CYC - 1);

  logic          armed_q;
  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      low_q   <= '0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (!enable_i) begin
        armed_q <= 1'b0;
        low_q   <= '0;
      end else if (pin_ni) begin
        armed_q <= 1'b1;
        low_q   <= '0;
      end else if (block_i) begin
        armed_q <= 1'b0;
        low_q   <= '0;
      end else if (armed_q) begin
        if (low_q == LAST) begin
          fire_o  <= 1'b1;
          armed_q <= 1'b0;
          low_q   <= '0;
        end else begin
          low_q <= low_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvg_strobe_gate.sv
module nvg_strobe_gate (
  input  logic rd_open_i,
  input  logic wr_open_i,
  input  logic store_ni,
  input  logic recall_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic rd_en_o,
  output logic wr_en_o
);
  logic pins_idle;
  assign pins_idle = store_ni & recall_ni;
  assign rd_en_o   = rd_req_i & rd_open_i & pins_idle;
  assign wr_en_o   = wr_req_i & wr_open_i & pins_idle;
endmodule

// File: rtl/nvram_guard.sv
module nvram_guard
  import nvram_guard_pkg::*;
#(
  parameter int unsigned RD_HOLD_CYC       = 10000,
  parameter int unsigned WR_HOLD_CYC       = 500000,
  parameter int unsigned STORE_MIN_LOW_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic por_i,
  input  logic store_ni,
  input  logic recall_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic store_req_o,
  output logic recall_req_o,
  output logic rd_en_o,
  output logic wr_en_o
);
  logic       restart, up;
  logic       rd_done, wr_done;
  logic       rd_open, wr_open;
  pwr_state_e state;

  assign restart = ~supply_ok_i | por_i;
  assign up      = ~restart;

  nvg_holdoff_timer #(.HOLD_CYC(RD_HOLD_CYC)) rd_tmr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(restart), .done_o(rd_done));

  nvg_holdoff_timer #(.HOLD_CYC(WR_HOLD_CYC)) wr_tmr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(restart), .done_o(wr_done));

  assign state   = pwr_state(up, rd_done, wr_done);
  assign rd_open = (state != PWR_DOWN);
  assign wr_open = (state == PWR_FULL) || (up && wr_done);

  nvg_pulse_qual #(.MIN_LOW_CYC(STORE_MIN_LOW_CYC)) store_q_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(wr_open),
    .pin_ni(store_ni), .block_i(~recall_ni), .fire_o(store_req_o));

  nvg_pulse_qual #(.MIN_LOW_CYC(1)) recall_q_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(rd_open),
    .pin_ni(recall_ni), .block_i(1'b0), .fire_o(recall_req_o));

  nvg_strobe_gate gate_i (
    .rd_open_i(rd_open), .wr_open_i(wr_open),
    .store_ni(store_ni), .recall_ni(recall_ni),
    .rd_req_i(rd_req_i), .wr_req_i(wr_req_i),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o));
endmodule

// File: rtl/nvram_guard_chk.sv
module nvram_guard_chk #(
  parameter int unsigned RD_HOLD_CYC       = 10000,
  parameter int unsigned WR_HOLD_CYC       = 500000,
  parameter int unsigned STORE_MIN_LOW_CYC = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic por_i,
  input logic store_ni,
  input logic recall_ni,
  input logic store_req_o,
  input logic recall_req_o,
  input logic rd_en_o,
  input logic wr_en_o
);
  logic [31:0] up_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  up_cnt <= '0;
    else if (!supply_ok_i || por_i) up_cnt <= '0;
    else if (up_cnt < WR_HOLD_CYC)  up_cnt <= up_cnt + 1;
  end

  // R1
  supply_low_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> (!rd_en_o && !wr_en_o));
  // R1
  supply_low_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!store_req_o && !recall_req_o));
  // R2
  rd_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (up_cnt >= RD_HOLD_CYC));
  // R3
  wr_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || store_req_o) |-> (up_cnt >= WR_HOLD_CYC || store_req_o));
  // R4
  pin_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!store_ni || !recall_ni) |-> (!rd_en_o && !wr_en_o));
  // R6
  store_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);
  // R8
  store_recall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> ($past(recall_ni) && !$past(store_ni)));
  // R9
  recall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);
  // R10
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!store_req_o && !recall_req_o);
    end
  end
endmodule

bind nvram_guard nvram_guard_chk #(
  .RD_HOLD_CYC(RD_HOLD_CYC), .WR_HOLD_CYC(WR_HOLD_CYC),
  .STORE_MIN_LOW_CYC(STORE_MIN_LOW_CYC)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .por_i(por_i),
  .store_ni(store_ni), .recall_ni(recall_ni), .store_req_o(store_req_o),
  .recall_req_o(recall_req_o), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o));

// File: tb/nvram_guard_tb_top.sv
module nvram_guard_tb_top;
  localparam int RD = 20;
  localparam int WR = 60;
  localparam int ML = 3;

  logic clk = 1'b0;
  logic rst_ni, supply_ok, por, store_n, recall_n, rd_req, wr_req;
  logic store_req, recall_req, rd_en, wr_en;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string phase = "R10 reset";

  // behavioural reference state
  int rd_cnt = 0, wr_cnt = 0;
  bit s_arm = 0, r_arm = 0;
  int s_low = 0;
  bit exp_store = 0, exp_recall = 0;

  always #5 clk = ~clk;

  nvram_guard #(.RD_HOLD_CYC(RD), .WR_HOLD_CYC(WR), .STORE_MIN_LOW_CYC(ML)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .por_i(por),
    .store_ni(store_n), .recall_ni(recall_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .store_req_o(store_req), .recall_req_o(recall_req), .rd_en_o(rd_en), .wr_en_o(wr_en));

  function automatic bit up_now();
    return supply_ok && !por;
  endfunction

  always @(posedge clk) begin
    bit rd_rdy, wr_rdy;
    if (!rst_ni) begin
      rd_cnt = 0; wr_cnt = 0; s_arm = 0; r_arm = 0; s_low = 0;
      exp_store = 0; exp_recall = 0;
    end else begin
      rd_rdy = up_now() && rd_cnt >= RD;
      wr_rdy = up_now() && wr_cnt >= WR;
      exp_store = 0; exp_recall = 0;
      if (!wr_rdy) begin s_arm = 0; s_low = 0; end
      else if (store_n) begin s_arm = 1; s_low = 0; end
      else if (!recall_n) begin s_arm = 0; s_low = 0; end
      else if (s_arm) begin
        s_low++;
        if (s_low >= ML) begin exp_store = 1; s_arm = 0; s_low = 0; end
      end
      if (!rd_rdy) r_arm = 0;
      else if (recall_n) r_arm = 1;
      else if (r_arm) begin exp_recall = 1; r_arm = 0; end
      if (!up_now()) begin rd_cnt = 0; wr_cnt = 0; end
      else begin
        if (rd_cnt < RD) rd_cnt++;
        if (wr_cnt < WR) wr_cnt++;
      end
    end
  end

  task automatic cmp(input string nm, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] t=%0t act=%b exp=%b", nm, phase, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit e_rd, e_wr, idle;
    #7;
    if (!finished) begin
      idle = store_n && recall_n;
      e_rd = rst_ni && rd_req && idle && up_now() && rd_cnt >= RD;
      e_wr = rst_ni && wr_req && idle && up_now() && wr_cnt >= WR;
      cmp("store_req_o R5", store_req, rst_ni ? exp_store : 1'b0);
      cmp("recall_req_o R9", recall_req, rst_ni ? exp_recall : 1'b0);
      cmp("rd_en_o R4", rd_en, e_rd);
      cmp("wr_en_o R4", wr_en, e_wr);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired (R1) act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; supply_ok = 1; por = 0; store_n = 1; recall_n = 1;
    rd_req = 1; wr_req = 1;
    cyc(4);
    rst_ni = 1;
    phase = "R2 R3 power-up hold-off";
    cyc(WR + 5);
    phase = "R4 host strobes";
    rd_req = 0; cyc(2); wr_req = 0; rd_req = 1; cyc(2); wr_req = 1; cyc(1);
    phase = "R1 supply drop";
    supply_ok = 0; cyc(3);
    phase = "R7 store held low through ramp";
    store_n = 0; cyc(1); supply_ok = 1; cyc(WR + 10);
    phase = "R5 R6 qualifying store pulse";
    store_n = 1; cyc(2); store_n = 0; cyc(ML + 6); store_n = 1; cyc(2);
    phase = "R5 glitch rejected";
    store_n = 0; cyc(ML - 1); store_n = 1; cyc(3);
    phase = "R8 recall cancels store";
    store_n = 0; cyc(1); recall_n = 0; cyc(1); recall_n = 1; cyc(ML + 3);
    store_n = 1; cyc(2);
    phase = "R8 R9 recall low before store";
    recall_n = 0; cyc(2); store_n = 0; cyc(ML + 2); store_n = 1; recall_n = 1; cyc(2);
    phase = "R9 recall pulse";
    recall_n = 0; cyc(5); recall_n = 1; cyc(2); recall_n = 0; cyc(1); recall_n = 1; cyc(2);
    phase = "R7 supply drop mid store";
    store_n = 0; cyc(ML - 1); supply_ok = 0; cyc(1); supply_ok = 1; cyc(WR + 4);
    store_n = 1; cyc(2);
    phase = "R2 por restart";
    por = 1; cyc(2); por = 0;
    store_n = 0; cyc(4); store_n = 1;
    recall_n = 0; cyc(2); recall_n = 1; cyc(RD + 2);
    recall_n = 0; cyc(2); recall_n = 1;
    store_n = 0; cyc(ML + 1); store_n = 1; cyc(WR);
    store_n = 0; cyc(ML + 1); store_n = 1; cyc(2);
    phase = "R10 reset mid run";
    store_n = 0; rst_ni = 0; cyc(3); rst_ni = 1; store_n = 1; cyc(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule